// File: doc/BRIEF.md
# XGMII 32-bit Frame Transmitter

This block turns a stream of Ethernet frame words into a 32-bit XGMII transmit stream with a 4-bit lane-control bus, one word per clock. It does not compute a CRC; it sends the bytes it is given. Each frame arrives as 32-bit words, with the lowest byte first in the lowest lane. While the first word is offered, the frame's total byte count and its transmit timestamp are held alongside it. The block fills the line with idle characters. Each frame then goes out as a start word, a preamble/delimiter word, the data words and a terminate word, and the terminate character sits in the lane that follows the last data byte.

Frames are paced in one of two ways. In fast mode, each frame starts as soon as the previous one has ended and one idle word has gone out. In timed mode, a free-running cycle counter is cleared by reset. The counter therefore measures elapsed cycles from reset release, and a frame waits until that count reaches its timestamp. When no frame is offered and the source signals end of stream, the block stays in a done state that sends idle.

Top module: `xgmii_frame_tx`

## Requirements
- R1: While reset is low, the outputs are data 0x07070707 with control 0xF, done 0, error 0, frame count 0 and in_ready 0.
- R2: Between frames, every word is idle (0x07070707 / 0xF), and there is at least one idle word before each start word. In fast mode there is exactly one idle word after each terminate word. The first frame after reset gives its start word on the 2nd clock edge after release.
- R3: The first word of a frame is 0x555555FB with control 0x1, so the start character 0xFB sits in lane 0 (bits 7:0).
- R4: The second word of a frame is 0xD5555555 with control 0x0, so the delimiter 0xD5 sits in lane 3 (bits 31:24).
- R5: While at least 4 bytes of the frame remain, the accepted input word is sent unchanged with control 0x0, in the order it was accepted.
- R6: With 3 bytes left, the word is {0xFD, byte2..byte0} with control 0x8. With 2 bytes left, it is {0x07, 0xFD, byte1..byte0} with control 0xC. With 1 byte left, it is {0x07, 0x07, 0xFD, byte0} with control 0xE. Input bytes beyond the frame length are dropped.
- R7: When the frame length is a multiple of 4, an extra word 0x070707FD with control 0xF follows the last data word.
- R8: In timed mode, the elapsed count is the number of clock edges since reset release. A frame with timestamp T whose previous frame ended at edge P (P = 0 for the first frame) gives its start word at edge max(T, P) + 2.
- R9: In fast mode, the timestamp has no effect. A frame's start word comes at edge P + 2.
- R10: When the block is idle between frames, no word is offered and end of stream is high, done goes high. After that it stays high and the output stays idle until reset.
- R11: in_ready is high only while a frame still needs input words. A frame of L bytes takes exactly ceil(L/4) words, and in_ready is low in reset and in the done state.
- R12: If no word is offered while in_ready is high, an idle word is sent in its place, the frame resumes with the next word offered, and the error flag sets and stays set until reset.
- R13: The frame count goes up by one for every terminate word sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| fast_mode | input | 1 | 1: frames back to back; 0: paced by timestamp |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word taken this cycle |
| in_data | input | 32 | Frame bytes, lowest byte in bits 7:0 |
| in_len | input | LEN_W (16) | Frame byte count, held with the frame |
| in_ts | input | TS_W (64) | Frame start time in cycles since reset release |
| in_eos | input | 1 | No further frames will be offered |
| xgmii_d | output | 32 | XGMII data, lane 0 in bits 7:0 |
| xgmii_c | output | 4 | XGMII control, bit n for lane n |
| done | output | 1 | All frames sent |
| err | output | 1 | Input ran dry in the middle of a frame (sticky) |
| tx_count | output | CNT_W (16) | Number of frames sent |

## Verification
The properties assume the source follows these rules. in_len is at least 1. in_len and in_ts stay fixed while in_valid is high for the first word of a frame. fast_mode changes only during reset. The stimulus keeps to all of this: a scoreboard table supplies lengths of at least one byte, and the driver changes the offered word only after a handshake. The driver gaps in_valid mid-frame only in the one directed case that targets the error flag.

// File: rtl/xtx_pkg.sv
package xtx_pkg;
  localparam int LANES  = 4;
  localparam int DATA_W = 8 * LANES;

  localparam logic [7:0] CH_IDLE  = 8'h07;
  localparam logic [7:0] CH_START = 8'hFB;
  localparam logic [7:0] CH_TERM  = 8'hFD;
  localparam logic [7:0] CH_PRE   = 8'h55;
  localparam logic [7:0] CH_SFD   = 8'hD5;

  localparam logic [DATA_W-1:0] IDLE_WORD  = {LANES{CH_IDLE}};
  localparam logic [LANES-1:0]  IDLE_CTL   = {LANES{1'b1}};
  localparam logic [DATA_W-1:0] START_WORD = {{(LANES-1){CH_PRE}}, CH_START};
  localparam logic [LANES-1:0]  START_CTL  = LANES'(1);
  localparam logic [DATA_W-1:0] SFD_WORD   = {CH_SFD, {(LANES-1){CH_PRE}}};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE1,
    ST_PRE2,
    ST_DATA,
    ST_DONE
  } xtx_state_e;
endpackage

// File: rtl/xtx_pace.sv
module xtx_pace #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fast,
  input  logic [TS_W-1:0] ts,
  output logic [TS_W-1:0] elapsed,
  output logic            go
);
  logic [TS_W-1:0] tick_q, tick_d;

  always_comb tick_d = tick_q + TS_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tick_q <= '0;
    else        tick_q <= tick_d;
  end

  assign elapsed = tick_q;
  assign go      = fast | (tick_q >= ts);
endmodule

// File: rtl/xtx_lane_fmt.sv
module xtx_lane_fmt
  import xtx_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic [LEN_W-1:0]  rem,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] data,
  output logic [LANES-1:0]  ctl,
  output logic              last
);
  logic tail;
  assign tail = rem < LEN_W'(LANES);
  assign last = tail;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] lane_d;
    logic       lane_c;
    always_comb begin
      if (!tail || (LEN_W'(i) < rem)) begin
        lane_d = word[8*i +: 8];
        lane_c = 1'b0;
      end else if (LEN_W'(i) == rem) begin
        lane_d = CH_TERM;
        lane_c = 1'b1;
      end else begin
        lane_d = CH_IDLE;
        lane_c = 1'b1;
      end
    end
    assign data[8*i +: 8] = lane_d;
    assign ctl[i]         = lane_c;
  end
endmodule

// File: rtl/xgmii_frame_tx.sv
module xgmii_frame_tx
  import xtx_pkg::*;
#(
  parameter int LEN_W = 16,
  parameter int TS_W  = 64,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fast_mode,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic [LEN_W-1:0]  in_len,
  input  logic [TS_W-1:0]   in_ts,
  input  logic              in_eos,
  output logic [DATA_W-1:0] xgmii_d,
  output logic [LANES-1:0]  xgmii_c,
  output logic              done,
  output logic              err,
  output logic [CNT_W-1:0]  tx_count
);
  xtx_state_e        st_q, st_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              err_q, err_d;
  logic [DATA_W-1:0] od_q, od_d;
  logic [LANES-1:0]  oc_q, oc_d;

  logic [TS_W-1:0]   elapsed;
  logic              go;
  logic [DATA_W-1:0] fmt_d;
  logic [LANES-1:0]  fmt_c;
  logic              fmt_last;
  logic              need_word;

  xtx_pace #(.TS_W(TS_W)) u_pace (
    .clk     (clk),
    .rst_n   (rst_n),
    .fast    (fast_mode),
    .ts      (in_ts),
    .elapsed (elapsed),
    .go      (go)
  );

  xtx_lane_fmt #(.LEN_W(LEN_W)) u_fmt (
    .rem  (rem_q),
    .word (in_data),
    .data (fmt_d),
    .ctl  (fmt_c),
    .last (fmt_last)
  );

  assign need_word = (rem_q != '0);
  assign in_ready  = (st_q == ST_DATA) && need_word;

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    cnt_d = cnt_q;
    err_d = err_q;
    od_d  = IDLE_WORD;
    oc_d  = IDLE_CTL;
    unique case (st_q)
      ST_IDLE: begin
        if (in_valid && go) begin
          st_d  = ST_PRE1;
          rem_d = in_len;
        end else if (!in_valid && in_eos) begin
          st_d = ST_DONE;
        end
      end
      ST_PRE1: begin
        od_d = START_WORD;
        oc_d = START_CTL;
        st_d = ST_PRE2;
      end
      ST_PRE2: begin
        od_d = SFD_WORD;
        oc_d = '0;
        st_d = ST_DATA;
      end
      ST_DATA: begin
        if (need_word && !in_valid) begin
          err_d = 1'b1;
        end else begin
          od_d = fmt_d;
          oc_d = fmt_c;
          if (fmt_last) begin
            st_d  = ST_IDLE;
            cnt_d = cnt_q + CNT_W'(1);
          end else begin
            rem_d = rem_q - LEN_W'(LANES);
          end
        end
      end
      ST_DONE: ;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
      cnt_q <= '0;
      err_q <= 1'b0;
      od_q  <= IDLE_WORD;
      oc_q  <= IDLE_CTL;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      cnt_q <= cnt_d;
      err_q <= err_d;
      od_q  <= od_d;
      oc_q  <= oc_d;
    end
  end

  assign xgmii_d  = od_q;
  assign xgmii_c  = oc_q;
  assign done     = (st_q == ST_DONE);
  assign err      = err_q;
  assign tx_count = cnt_q;

  // R3 R4
  start_then_sfd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xgmii_c == START_CTL && xgmii_d == START_WORD) |=> (xgmii_c == '0 && xgmii_d == SFD_WORD));

  // R2
  term_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((xgmii_c inside {4'h8, 4'hC, 4'hE}) || (xgmii_c == 4'hF && xgmii_d[7:0] == CH_TERM))
    |=> (xgmii_c == IDLE_CTL && xgmii_d == IDLE_WORD));

  // R8
  pace_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PRE1) |-> $past(fast_mode || (elapsed >= in_ts)));

  // R10
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (done && xgmii_d == IDLE_WORD && xgmii_c == IDLE_CTL));

  // R12
  starve_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> (err && xgmii_c == IDLE_CTL));

  // R12
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);
endmodule

// File: tb/test_xgmii_frame_tx.sv
module test_xgmii_frame_tx;
  localparam int CAP_N = 512;
  localparam int N_FR  = 11;
  // frame table: length in bytes and timestamp in cycles
  localparam int FR_LEN [0:N_FR-1] = '{5, 2, 3, 4, 1, 8, 11, 6, 4, 9, 8};
  localparam int FR_TS  [0:N_FR-1] = '{50, 0, 7, 3, 9, 1, 2, 30, 32, 90, 0};

  logic        clk = 1'b0;
  logic        rst_n;
  logic        fast_mode;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_data;
  logic [15:0] in_len;
  logic [63:0] in_ts;
  logic        in_eos;
  logic [31:0] xgmii_d;
  logic [3:0]  xgmii_c;
  logic        done;
  logic        err;
  logic [15:0] tx_count;

  int checks = 0;
  int errors = 0;
  int cyc;
  int hs_cnt;
  int f_begin, f_end, starve_j;
  int cur_f, cur_j, starve_left;
  bit fire_q;
  logic [31:0] cap_d [0:CAP_N-1];
  logic [3:0]  cap_c [0:CAP_N-1];

  always #4 clk = ~clk;

  xgmii_frame_tx i_xgmii_frame_tx (
    .clk(clk), .rst_n(rst_n), .fast_mode(fast_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_data(in_data), .in_len(in_len), .in_ts(in_ts),
    .in_eos(in_eos), .xgmii_d(xgmii_d), .xgmii_c(xgmii_c), .done(done),
    .err(err), .tx_count(tx_count)
  );

  function automatic logic [31:0] wd(int f, int j);
    logic [7:0] fb = 8'(f);
    logic [7:0] jb = 8'(j);
    return {8'h80 | fb, 8'h40 | jb, 8'h9C, 8'h21 + fb};
  endfunction

  function automatic int nwords(int f);
    return (FR_LEN[f] + 3) / 4;
  endfunction

  function automatic logic [35:0] exp_tail(int r, logic [31:0] w);
    case (r)
      3:       return {4'h8, 8'hFD, w[23:0]};
      2:       return {4'hC, 8'h07, 8'hFD, w[15:0]};
      1:       return {4'hE, 16'h0707, 8'hFD, w[7:0]};
      default: return {4'hF, 32'h070707FD};
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [35:0] act, input logic [35:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_cap(input int idx, input logic [35:0] exp, input string tag);
    logic [35:0] act = {cap_c[idx], cap_d[idx]};
    chk(act === exp, tag, act, exp);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc    <= 0;
      hs_cnt <= 0;
    end else begin
      cyc <= cyc + 1;
      if (in_valid && in_ready) hs_cnt <= hs_cnt + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && cyc < CAP_N) begin
      cap_d[cyc] = xgmii_d;
      cap_c[cyc] = xgmii_c;
    end
  end

  // source driver: changes the offered word only after a handshake
  always @(negedge clk) begin
    if (!rst_n) begin
      cur_f       = f_begin;
      cur_j       = 0;
      fire_q      = 1'b0;
      starve_left = 2;
    end else if (fire_q) begin
      cur_j++;
      if (cur_j >= nwords(cur_f)) begin
        cur_j = 0;
        cur_f++;
      end
    end
    if (cur_f < f_end) begin
      in_valid = 1'b1;
      in_len   = 16'(FR_LEN[cur_f]);
      in_ts    = 64'(FR_TS[cur_f]);
      in_data  = wd(cur_f, cur_j);
    end else begin
      in_valid = 1'b0;
      in_len   = '0;
      in_ts    = '0;
      in_data  = '0;
    end
    if (rst_n && cur_j == starve_j && starve_left > 0 && in_ready) begin
      in_valid = 1'b0;
      starve_left--;
    end
    fire_q = in_valid && in_ready;
  end

  task automatic run(input int fb, input int fe, input bit fast, input int sj);
    rst_n     = 1'b0;
    fast_mode = fast;
    f_begin   = fb;
    f_end     = fe;
    starve_j  = sj;
    repeat (3) @(negedge clk);
    // R1
    chk({xgmii_c, xgmii_d} === 36'hF07070707, "R1 reset output", {xgmii_c, xgmii_d}, 36'hF07070707);
    chk({done, err, in_ready, tx_count} === 19'h0, "R1 reset flags",
        36'({done, err, in_ready, tx_count}), 36'h0);
    rst_n = 1'b1;
    for (int i = 0; i < 400 && !done; i++) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_frames(input int fb, input int fe, input bit fast);
    int prev  = 0;
    int words = 0;
    for (int f = fb; f < fe; f++) begin
      int start = fast ? prev + 2 : ((FR_TS[f] > prev ? FR_TS[f] : prev) + 2);
      int left  = FR_LEN[f];
      int nw    = nwords(f);
      int bad   = 0;
      int term  = 0;
      words += nw;
      for (int k = prev + 1; k < start; k++)
        if ({cap_c[k], cap_d[k]} !== 36'hF07070707) bad++;
      // R2
      chk(bad == 0 && start - prev >= 2, "R2 idle gap", 36'(bad), 36'h0);
      // R3 R8 R9
      chk_cap(start, 36'h1555555FB, fast ? "R3 R9 start word" : "R3 R8 start word");
      // R4
      chk_cap(start + 1, 36'h0D5555555, "R4 delimiter word");
      for (int j = 0; j < nw; j++) begin
        if (left >= 4) begin
          chk_cap(start + 2 + j, {4'h0, wd(f, j)}, "R5 data word");
          left -= 4;
          term = start + 2 + j;
        end else begin
          chk_cap(start + 2 + j, exp_tail(left, wd(f, j)), "R6 tail word");
          left = 0;
          term = start + 2 + j;
        end
      end
      if (FR_LEN[f] % 4 == 0) begin
        term = start + 2 + nw;
        chk_cap(term, 36'hF070707FD, "R7 extra terminate word");
      end
      prev = term;
    end
    // R10
    chk_cap(prev + 1, 36'hF07070707, "R10 idle after last frame");
    chk(done === 1'b1 && xgmii_c === 4'hF && xgmii_d === 32'h07070707, "R10 done idle",
        {xgmii_c, xgmii_d}, 36'hF07070707);
    // R11
    chk(hs_cnt == words && in_ready === 1'b0, "R11 words taken", 36'(hs_cnt), 36'(words));
    // R13
    chk(tx_count == 16'(fe - fb), "R13 frame count", 36'(tx_count), 36'(fe - fb));
    // R12
    chk(err === 1'b0, "R12 no error", 36'(err), 36'h0);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    in_eos = 1'b1;
    // fast mode: all residues, first timestamp large yet ignored
    run(0, 7, 1'b1, -1);
    check_frames(0, 7, 1'b1);
    // timed mode: waiting frame, blocked frame, late frame
    run(7, 10, 1'b0, -1);
    check_frames(7, 10, 1'b0);
    // starvation mid-frame: R12
    run(10, 11, 1'b1, 1);
    chk_cap(2, 36'h1555555FB, "R12 start");
    chk_cap(4, {4'h0, wd(10, 0)}, "R12 word before gap");
    chk_cap(5, 36'hF07070707, "R12 idle fill 1");
    chk_cap(6, 36'hF07070707, "R12 idle fill 2");
    chk_cap(7, {4'h0, wd(10, 1)}, "R12 resumed word");
    chk_cap(8, 36'hF070707FD, "R12 R7 terminate");
    chk(err === 1'b1, "R12 error sticky", 36'(err), 36'h1);
    chk(tx_count == 16'd1 && done === 1'b1, "R13 R10 after starve", 36'(tx_count), 36'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule